// File: doc/BRIEF.md
# Hierarchical Tiled Address Translator

This block turns a two-dimensional byte coordinate into a linear byte address. It is meant for the load/store path of a datapath that works on images or matrices. In tiled mode the image is stored as nested square tiles. The address space is cut into 2048×2048-byte large tiles, each large tile into 64×64-byte medium tiles, and each medium tile into 8×8-byte fine tiles. At every level the children of a tile are placed one row after another, left to right, and the bytes inside a fine tile follow the same order. Software hands over only the coordinate, a base address and the number of large tiles across the image, and the hardware does all of the address arithmetic.

A mode input selects plain raster addressing instead, in which the address is the base plus the row times a row pitch plus the column. The same unit can therefore serve ordinary line accesses and two-dimensional tile accesses, and the mode can change on each request. Every request gives a registered result one clock later, with a valid flag that follows the request.

Top module: `tile_addr_xlat`

## Requirements
- R1: While rst is high at a rising clock edge, out_valid becomes 0 and out_addr becomes 0 after that edge.
- R2: A request accepted with req_valid=1 at a rising edge gives out_valid=1 and its address after that same edge. The latency is exactly one cycle, and requests may come on consecutive cycles.
- R3: In tiled mode (req_tiled=1) the bytes of an 8×8 fine tile are in raster order: the address contains (y mod 8)·8 + (x mod 8).
- R4: In tiled mode, the fine tiles inside a 64×64 medium tile are in raster order with a stride of 64 bytes. The term is (((y mod 64)/8)·8 + (x mod 64)/8)·64.
- R5: In tiled mode, the medium tiles inside a 2048×2048 large tile are in raster order with a stride of 4096 bytes and 32 tiles per row. The term is (((y mod 2048)/64)·32 + (x mod 2048)/64)·4096.
- R6: In tiled mode, the large tile index is (y/2048)·tiles_per_row + x/2048. Each large tile takes 4 MiB (4194304 bytes), and the sum of all terms is added to base.
- R7: In raster mode (req_tiled=0) the address is base + y·row_pitch + x. In this mode tiles_per_row has no effect on the address.
- R8: The mode is sampled with each request. Requests of alternating modes on consecutive cycles each get the address for their own mode.
- R9: A cycle with req_valid=0 gives out_valid=0 after the next edge. In that cycle out_addr keeps its previous value, whatever the other inputs are.
- R10: All address arithmetic wraps modulo 2^ADDR_W (2^32 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_tiled | input | 1 | 1 = tiled translation, 0 = raster |
| req_x | input | COORD_W (16) | Column byte coordinate |
| req_y | input | COORD_W (16) | Row byte coordinate |
| base | input | ADDR_W (32) | Image base byte address |
| row_pitch | input | PITCH_W (20) | Bytes per raster row |
| tiles_per_row | input | TPR_W (8) | Large tiles across the image in tiled mode |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_addr | output | ADDR_W (32) | Translated byte address |

## Verification
A full scan of one fine tile with a zero base shows whether the row and column offsets are swapped or mis-scaled at the innermost level. Walks along single axes, each with a step of 8 and then 64, separate the fine-tile stride from the medium-tile stride and the 8-wide row from the 32-wide row. Large-tile coordinates with several tiles_per_row values show that the row count is multiplied and the column added. Raster sweeps with odd pitches, alternating-mode bursts, idle cycles carrying junk inputs, and bases near the top of the address space test the mode select, the hold behaviour and the modulo wrap.

// File: rtl/tile_xlat_pkg.sv
`timescale 1ns/1ps
package tile_xlat_pkg;

    // Default geometry: log2 of the tile edge at each level
    localparam int FINE_LOG_D  = 3;   // 8 x 8
    localparam int MID_LOG_D   = 6;   // 64 x 64
    localparam int LARGE_LOG_D = 11;  // 2048 x 2048

    localparam int COORD_W_D = 16;
    localparam int ADDR_W_D  = 32;
    localparam int PITCH_W_D = 20;
    localparam int TPR_W_D   = 8;

    // Select a translation mode from the request bit
    typedef enum logic {
        XM_RASTER = 1'b0,
        XM_TILED  = 1'b1
    } xlat_mode_e;

    function automatic xlat_mode_e decode_mode(input logic tiled_bit);
        return tiled_bit ? XM_TILED : XM_RASTER;
    endfunction

    // Number of bits in the per-axis field of a tile level
    function automatic int level_bits(input int outer_log, input int inner_log);
        return outer_log - inner_log;
    endfunction

endpackage

// File: rtl/tile_coord_split.sv
`timescale 1ns/1ps
module tile_coord_split
    import tile_xlat_pkg::*;
#(
    parameter int COORD_W   = COORD_W_D,
    parameter int FINE_LOG  = FINE_LOG_D,
    parameter int MID_LOG   = MID_LOG_D,
    parameter int LARGE_LOG = LARGE_LOG_D,
    localparam int FINE_W   = FINE_LOG,
    localparam int SMALL_W  = MID_LOG - FINE_LOG,
    localparam int MEDIUM_W = LARGE_LOG - MID_LOG,
    localparam int LARGE_W  = COORD_W - LARGE_LOG
) (
    input  logic [COORD_W-1:0]  x_in,
    input  logic [COORD_W-1:0]  y_in,
    // index 0 = column axis, 1 = row axis
    output logic [1:0][FINE_W-1:0]   fine_f,
    output logic [1:0][SMALL_W-1:0]  small_f,
    output logic [1:0][MEDIUM_W-1:0] medium_f,
    output logic [1:0][LARGE_W-1:0]  large_f
);

    logic [1:0][COORD_W-1:0] coord;

    always_comb begin
        coord[0] = x_in;
        coord[1] = y_in;
    end

    for (genvar ax = 0; ax < 2; ax++) begin : g_axis
        always_comb begin
            fine_f[ax]   = coord[ax][FINE_LOG-1:0];
            small_f[ax]  = coord[ax][MID_LOG-1:FINE_LOG];
            medium_f[ax] = coord[ax][LARGE_LOG-1:MID_LOG];
            large_f[ax]  = coord[ax][COORD_W-1:LARGE_LOG];
        end
    end

endmodule

// File: rtl/tile_offset_build.sv
`timescale 1ns/1ps
module tile_offset_build
    import tile_xlat_pkg::*;
#(
    parameter int COORD_W   = COORD_W_D,
    parameter int ADDR_W    = ADDR_W_D,
    parameter int TPR_W     = TPR_W_D,
    parameter int FINE_LOG  = FINE_LOG_D,
    parameter int MID_LOG   = MID_LOG_D,
    parameter int LARGE_LOG = LARGE_LOG_D,
    localparam int FINE_W   = FINE_LOG,
    localparam int SMALL_W  = MID_LOG - FINE_LOG,
    localparam int MEDIUM_W = LARGE_LOG - MID_LOG,
    localparam int LARGE_W  = COORD_W - LARGE_LOG,
    localparam int INNER_W  = 2 * LARGE_LOG,
    localparam int LIDX_W   = LARGE_W + TPR_W + 1
) (
    input  logic [1:0][FINE_W-1:0]   fine_f,
    input  logic [1:0][SMALL_W-1:0]  small_f,
    input  logic [1:0][MEDIUM_W-1:0] medium_f,
    input  logic [1:0][LARGE_W-1:0]  large_f,
    input  logic [TPR_W-1:0]         tiles_per_row,
    input  logic [ADDR_W-1:0]        base,
    output logic [ADDR_W-1:0]        tiled_addr
);

    // Offset inside one large tile. All edges are powers of two, so each
    // level's row-major index is its row field followed by its column field.
    typedef struct packed {
        logic [MEDIUM_W-1:0] med_row;
        logic [MEDIUM_W-1:0] med_col;
        logic [SMALL_W-1:0]  sml_row;
        logic [SMALL_W-1:0]  sml_col;
        logic [FINE_W-1:0]   fin_row;
        logic [FINE_W-1:0]   fin_col;
    } inner_ofs_t;

    inner_ofs_t          inner;
    logic [LIDX_W-1:0]   large_idx;
    logic [ADDR_W-1:0]   large_term;
    logic [ADDR_W-1:0]   inner_term;

    always_comb begin
        inner.med_row = medium_f[1];
        inner.med_col = medium_f[0];
        inner.sml_row = small_f[1];
        inner.sml_col = small_f[0];
        inner.fin_row = fine_f[1];
        inner.fin_col = fine_f[0];
    end

    always_comb begin
        large_idx  = LIDX_W'(large_f[1]) * LIDX_W'(tiles_per_row)
                   + LIDX_W'(large_f[0]);
        large_term = ADDR_W'(large_idx) << INNER_W;
        inner_term = ADDR_W'(inner);
        tiled_addr = base + large_term + inner_term;
    end

endmodule

// File: rtl/raster_addr_calc.sv
`timescale 1ns/1ps
module raster_addr_calc
    import tile_xlat_pkg::*;
#(
    parameter int COORD_W = COORD_W_D,
    parameter int ADDR_W  = ADDR_W_D,
    parameter int PITCH_W = PITCH_W_D
) (
    input  logic [COORD_W-1:0] x_in,
    input  logic [COORD_W-1:0] y_in,
    input  logic [PITCH_W-1:0] row_pitch,
    input  logic [ADDR_W-1:0]  base,
    output logic [ADDR_W-1:0]  raster_addr
);

    logic [ADDR_W-1:0] row_term;

    always_comb begin
        row_term    = ADDR_W'(y_in) * ADDR_W'(row_pitch);
        raster_addr = base + row_term + ADDR_W'(x_in);
    end

endmodule

// File: rtl/tile_addr_xlat.sv
`timescale 1ns/1ps
module tile_addr_xlat
    import tile_xlat_pkg::*;
#(
    parameter int COORD_W   = COORD_W_D,
    parameter int ADDR_W    = ADDR_W_D,
    parameter int PITCH_W   = PITCH_W_D,
    parameter int TPR_W     = TPR_W_D,
    parameter int FINE_LOG  = FINE_LOG_D,
    parameter int MID_LOG   = MID_LOG_D,
    parameter int LARGE_LOG = LARGE_LOG_D
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_tiled,
    input  logic [COORD_W-1:0] req_x,
    input  logic [COORD_W-1:0] req_y,
    input  logic [ADDR_W-1:0]  base,
    input  logic [PITCH_W-1:0] row_pitch,
    input  logic [TPR_W-1:0]   tiles_per_row,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_addr
);

    localparam int FINE_W   = level_bits(FINE_LOG, 0);
    localparam int SMALL_W  = level_bits(MID_LOG, FINE_LOG);
    localparam int MEDIUM_W = level_bits(LARGE_LOG, MID_LOG);
    localparam int LARGE_W  = level_bits(COORD_W, LARGE_LOG);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } xlat_out_t;

    logic [1:0][FINE_W-1:0]   fine_f;
    logic [1:0][SMALL_W-1:0]  small_f;
    logic [1:0][MEDIUM_W-1:0] medium_f;
    logic [1:0][LARGE_W-1:0]  large_f;
    logic [ADDR_W-1:0]        tiled_addr;
    logic [ADDR_W-1:0]        raster_addr;
    xlat_mode_e               mode;
    xlat_out_t                out_q;
    xlat_out_t                out_d;

    tile_coord_split #(
        .COORD_W  (COORD_W),
        .FINE_LOG (FINE_LOG),
        .MID_LOG  (MID_LOG),
        .LARGE_LOG(LARGE_LOG)
    ) u_split (
        .x_in    (req_x),
        .y_in    (req_y),
        .fine_f  (fine_f),
        .small_f (small_f),
        .medium_f(medium_f),
        .large_f (large_f)
    );

    tile_offset_build #(
        .COORD_W  (COORD_W),
        .ADDR_W   (ADDR_W),
        .TPR_W    (TPR_W),
        .FINE_LOG (FINE_LOG),
        .MID_LOG  (MID_LOG),
        .LARGE_LOG(LARGE_LOG)
    ) u_tiled (
        .fine_f       (fine_f),
        .small_f      (small_f),
        .medium_f     (medium_f),
        .large_f      (large_f),
        .tiles_per_row(tiles_per_row),
        .base         (base),
        .tiled_addr   (tiled_addr)
    );

    raster_addr_calc #(
        .COORD_W(COORD_W),
        .ADDR_W (ADDR_W),
        .PITCH_W(PITCH_W)
    ) u_raster (
        .x_in       (req_x),
        .y_in       (req_y),
        .row_pitch  (row_pitch),
        .base       (base),
        .raster_addr(raster_addr)
    );

    always_comb begin
        mode        = decode_mode(req_tiled);
        out_d.valid = req_valid;
        out_d.addr  = out_q.addr;
        if (req_valid) begin
            case (mode)
                XM_TILED:  out_d.addr = tiled_addr;
                default:   out_d.addr = raster_addr;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_addr  = out_q.addr;

endmodule

// File: rtl/tile_addr_xlat_chk.sv
`timescale 1ns/1ps
module tile_addr_xlat_chk #(
    parameter int COORD_W  = 16,
    parameter int ADDR_W   = 32,
    parameter int PITCH_W  = 20,
    parameter int TPR_W    = 8,
    parameter int FINE_LOG = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_tiled,
    input logic [COORD_W-1:0] req_x,
    input logic [COORD_W-1:0] req_y,
    input logic [ADDR_W-1:0]  base,
    input logic [PITCH_W-1:0] row_pitch,
    input logic [TPR_W-1:0]   tiles_per_row,
    input logic               out_valid,
    input logic [ADDR_W-1:0]  out_addr
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && out_addr == '0)); // R1

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid); // R2

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid); // R9

    AST_IDLE_HOLDS_ADDR: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(out_addr)); // R9

    AST_FINE_COLUMN: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_tiled) |=>
            out_addr[FINE_LOG-1:0] ==
            FINE_LOG'($past(base[FINE_LOG-1:0]) + $past(req_x[FINE_LOG-1:0]))); // R3

    AST_RASTER_ROW0: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_tiled && req_y == '0) |=>
            out_addr == ADDR_W'($past(base) + ADDR_W'($past(req_x)))); // R7

endmodule

bind tile_addr_xlat tile_addr_xlat_chk #(
    .COORD_W (COORD_W),
    .ADDR_W  (ADDR_W),
    .PITCH_W (PITCH_W),
    .TPR_W   (TPR_W),
    .FINE_LOG(FINE_LOG)
) i_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_tiled    (req_tiled),
    .req_x        (req_x),
    .req_y        (req_y),
    .base         (base),
    .row_pitch    (row_pitch),
    .tiles_per_row(tiles_per_row),
    .out_valid    (out_valid),
    .out_addr     (out_addr)
);

// File: tb/test_tile_addr_xlat.sv
`timescale 1ns/1ps
module test_tile_addr_xlat;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_tiled = 1'b0;
    logic [15:0] req_x = '0;
    logic [15:0] req_y = '0;
    logic [31:0] base = '0;
    logic [19:0] row_pitch = '0;
    logic [7:0]  tiles_per_row = '0;
    logic        out_valid;
    logic [31:0] out_addr;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk; // 50 MHz

    tile_addr_xlat i_tile_addr_xlat (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_tiled    (req_tiled),
        .req_x        (req_x),
        .req_y        (req_y),
        .base         (base),
        .row_pitch    (row_pitch),
        .tiles_per_row(tiles_per_row),
        .out_valid    (out_valid),
        .out_addr     (out_addr)
    );

    function automatic logic [31:0] model_tiled(input longint x, input longint y,
                                                input longint b, input longint tpr);
        longint lg, md, sm, fn, a;
        lg = (y / 2048) * tpr + (x / 2048);
        md = ((y % 2048) / 64) * 32 + ((x % 2048) / 64);
        sm = ((y % 64) / 8) * 8 + ((x % 64) / 8);
        fn = (y % 8) * 8 + (x % 8);
        a  = b + lg * 4194304 + md * 4096 + sm * 64 + fn;
        return a[31:0];
    endfunction

    function automatic logic [31:0] model_raster(input longint x, input longint y,
                                                 input longint b, input longint p);
        longint a;
        a = b + y * p + x;
        return a[31:0];
    endfunction

    task automatic check(input string tag, input logic v, input logic [31:0] a,
                         input logic ev, input logic [31:0] ea);
        n_checks++;
        if (v !== ev || a !== ea) begin
            n_fail++;
            $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
                     tag, v, a, ev, ea);
        end
    endtask

    // Issue one request at a falling edge, check its result one edge later
    task automatic issue(input string tag, input logic tiled,
                         input int x, input int y);
        logic [31:0] exp;
        req_valid = 1'b1;
        req_tiled = tiled;
        req_x     = x[15:0];
        req_y     = y[15:0];
        exp = tiled ? model_tiled(x, y, base, tiles_per_row)
                    : model_raster(x, y, base, row_pitch);
        @(negedge clk);
        check(tag, out_valid, out_addr, 1'b1, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        req_valid = 1'b1;
        req_tiled = 1'b1;
        req_x = 16'h1234;
        base = 32'hDEAD_0000;
        repeat (2) @(negedge clk);
        check("R1 reset state", out_valid, out_addr, 1'b0, 32'h0);
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_fine();
        base = 32'h0;
        tiles_per_row = 8'd4;
        for (int y = 0; y < 8; y++)
            for (int x = 0; x < 8; x++)
                issue("R3 fine tile raster", 1'b1, x, y);
        issue("R3 fine corner 7,7 = 63", 1'b1, 7, 7);
    endtask

    task automatic t_small();
        base = 32'h1000_0000;
        for (int i = 0; i < 8; i++) issue("R4 small stride column", 1'b1, 8 * i + 1, 2);
        for (int j = 0; j < 8; j++) issue("R4 small stride row", 1'b1, 3, 8 * j + 5);
        issue("R4 last small tile", 1'b1, 63, 63);
    endtask

    task automatic t_medium();
        base = 32'h0;
        for (int i = 0; i < 32; i += 5) issue("R5 medium stride column", 1'b1, 64 * i, 0);
        for (int j = 0; j < 32; j += 7) issue("R5 medium stride row", 1'b1, 0, 64 * j);
        issue("R5 last medium tile", 1'b1, 2047, 2047);
    endtask

    task automatic t_large();
        base = 32'h0040_0000;
        tiles_per_row = 8'd3;
        issue("R6 large index 5", 1'b1, 2048 * 2 + 5, 2048 + 9);
        tiles_per_row = 8'd7;
        issue("R6 large row scaled", 1'b1, 2048 * 6 + 100, 2048 * 2 + 300);
        tiles_per_row = 8'd1;
        issue("R6 one tile per row", 1'b1, 0, 2048 * 3);
        tiles_per_row = 8'd32;
        issue("R6 wide image", 1'b1, 65535, 4095);
    endtask

    task automatic t_raster();
        base = 32'h2000_0000;
        row_pitch = 20'd1920;
        tiles_per_row = 8'd9;
        issue("R7 raster origin", 1'b0, 0, 0);
        issue("R7 raster row 1", 1'b0, 17, 1);
        issue("R7 raster far", 1'b0, 1919, 1079);
        tiles_per_row = 8'd200;
        issue("R7 tiles_per_row no effect", 1'b0, 1919, 1079);
        row_pitch = 20'd777;
        issue("R7 odd pitch", 1'b0, 33, 501);
    endtask

    task automatic t_switch();
        base = 32'h0300_0000;
        row_pitch = 20'd4096;
        tiles_per_row = 8'd2;
        for (int k = 0; k < 6; k++)
            issue("R8 alternating mode", k[0], 2048 + 70 + k, 2048 + 9 + k);
    endtask

    task automatic t_idle();
        logic [31:0] held;
        base = 32'h0;
        tiles_per_row = 8'd2;
        issue("R2 request before idle", 1'b1, 300, 200);
        held = out_addr;
        req_valid = 1'b0;
        req_tiled = 1'b0;
        req_x = 16'hFFFF;
        req_y = 16'hAAAA;
        base = 32'h5555_5555;
        @(negedge clk);
        check("R9 idle clears valid, holds addr", out_valid, out_addr, 1'b0, held);
        @(negedge clk);
        check("R9 second idle cycle", out_valid, out_addr, 1'b0, held);
        issue("R2 resume after idle", 1'b0, 1, 1);
    endtask

    task automatic t_wrap();
        base = 32'hFFFF_FFF0;
        row_pitch = 20'd16;
        issue("R10 raster wrap", 1'b0, 32'h20, 0);
        check("R10 raster wrap value", out_valid, out_addr, 1'b1, 32'h0000_0010);
        base = 32'hFFF0_0000;
        tiles_per_row = 8'd255;
        issue("R10 tiled wrap", 1'b1, 2048 * 10, 2048 * 31);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_fine();
        t_small();
        t_medium();
        t_large();
        t_raster();
        t_switch();
        t_idle();
        t_wrap();
        req_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule